// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the serial core of an SPI master. Words come in on a valid/ready stream, go out most-significant bit first on MOSI, and words built from MISO leave on a one-cycle valid strobe. A small write-only register port sets the frame size, clock polarity and phase, transfer mode, internal loopback, baud divider, chip-select mask, receive-only frame count and a run/enable bit. Only the Motorola SPI frame format is built.

A frame starts when the engine is enabled, the divider is non-zero and the selected mode has work. In the two transmit modes the work is a waiting transmit word. In receive-only mode the work is the frames still owed from the programmed count. The select lines stay low across back-to-back frames and rise one half SCLK period after the final edge. Clearing the enable bit abandons a frame at once.

Register port (cfg_addr): 0 control word, 1 divider, 2 enable (bit 0), 3 select mask, 4 receive-only frame count. Control word fields: [3:0] bits per frame minus one, [5:4] transfer mode, [6] clock phase, [7] clock polarity, [8] loopback.

Top module: `spi_master_engine`

## Requirements
- R1: After reset all ss_n lines are high, sclk and mosi are low, and rx_valid and tx_ready are low.
- R2: A frame-size field of 15 gives 16-bit frames; any other value gives 8-bit frames. Bits go out MSB first. Transmit bits above the frame width are ignored, and rx_data bits above the width read as zero.
- R3: Control bit 7 sets the level of the idle SCLK. With control bit 6 clear, MISO is sampled on the leading edge of each SCLK cycle. With it set, MISO is sampled on the trailing edge.
- R4: Transfer mode 00 sends and receives. Mode 01 sends and never raises rx_valid. Mode 10 keeps MOSI low and receives frames without taking transmit words. Mode 11 starts no frame.
- R5: The divider's bit 0 is forced to zero. Each SCLK half period lasts divider/2 system clocks. A divider of zero starts no frame and gives no SCLK edge.
- R6: During a frame only the ss_n lines whose bits are set in the select mask go low.
- R7: The first SCLK edge comes one half period after ss_n falls, and ss_n rises one half period after the last edge. Between back-to-back frames ss_n stays low.
- R8: Writes to the control word, divider, select mask and frame count are ignored while the engine is enabled.
- R9: Clearing the enable bit during a frame drives ss_n high and SCLK to its idle level on the next cycle, and that frame gives no rx_valid.
- R10: With loopback set, the receive shifter takes its input from MOSI and ignores MISO.
- R11: In receive-only mode the frame count is taken when the engine is enabled. Exactly that many frames run, with the select held low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | FRAME_W | Transmit word |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | FRAME_W | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NCS | Active-low device selects |

## Verification
The properties assume that configuration words reach the engine only through the register port. They also assume that the enable bit and a locked register are never written in the same cycle, since there is one address per write. The stimulus writes the control word, divider, mask and count only with the engine disabled. The one exception is the lock test, which writes them on purpose while enabled and expects them to have no effect. The bench's slave model changes MISO only after the engine's sampling edge, and it holds tx_valid and tx_data steady until tx_ready is seen.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        XM_DUPLEX = 2'b00,
        XM_SEND   = 2'b01,
        XM_RECV   = 2'b10,
        XM_RSVD   = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } seq_state_e;

    // control word layout, MSB first: loop[8] cpol[7] cpha[6] mode[5:4] size_m1[3:0]
    typedef struct packed {
        logic       loop;
        logic       cpol;
        logic       cpha;
        xfer_mode_e mode;
        logic [3:0] size_m1;
    } eng_cfg_t;

    localparam int REG_W     = 16;
    localparam int ADDR_W    = 3;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_DIV  = 1;
    localparam int ADDR_EN   = 2;
    localparam int ADDR_SEL  = 3;
    localparam int ADDR_CNT  = 4;

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int NCS   = 4,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output eng_cfg_t          cfg,
    output logic [DIV_W-1:0]  div,
    output logic              en,
    output logic [NCS-1:0]    mask,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        eng_cfg_t         cfg;
        logic [DIV_W-1:0] div;
        logic             en;
        logic [NCS-1:0]   mask;
        logic [CNT_W-1:0] count;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (int'(addr))
                ADDR_CTRL: if (!r_q.en) r_d.cfg = eng_cfg_t'(wdata[8:0]);
                ADDR_DIV:  if (!r_q.en) r_d.div = {wdata[DIV_W-1:1], 1'b0};
                ADDR_EN:   r_d.en = wdata[0];
                ADDR_SEL:  if (!r_q.en) r_d.mask = wdata[NCS-1:0];
                ADDR_CNT:  if (!r_q.en) r_d.count = wdata[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg   = r_q.cfg;
    assign div   = r_q.div;
    assign en    = r_q.en;
    assign mask  = r_q.mask;
    assign count = r_q.count;
endmodule

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int HALF_W = DIV_W - 1;
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    logic [HALF_W-1:0] half;
    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        half  = div[DIV_W-1:1];
        tick  = run && (half != '0) && ((cnt_q + ONE) == half);
        cnt_d = (!run || tick) ? '0 : cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int W     = 16,
    parameter int NCS   = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  eng_cfg_t         cfg,
    input  logic             div_nz,
    input  logic [NCS-1:0]   mask,
    input  logic [CNT_W-1:0] count,
    input  logic             tick,
    input  logic             tx_valid,
    input  logic [W-1:0]     tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [W-1:0]     rx_data,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic [NCS-1:0]   ss_n,
    output logic             run
);
    localparam int HW = W / 2;
    localparam int EW = $clog2(2 * W);

    typedef struct packed {
        seq_state_e       st;
        logic             ph;
        logic [W-1:0]     txsr;
        logic [W-1:0]     rxsr;
        logic [EW-1:0]    ecnt;
        logic [CNT_W-1:0] left;
        logic             en_prev;
        logic             rxv;
        logic [W-1:0]     rxd;
    } seq_t;

    seq_t s_d, s_q;

    logic             wide, txbit, rin, want, can_go, edge_go, lead, samp, load;
    logic [EW-1:0]    e, last_e;
    logic [W-1:0]     nrx;
    logic [CNT_W-1:0] left_eff;

    assign wide   = (cfg.size_m1 == 4'(W - 1));
    assign last_e = wide ? EW'(2 * W - 1) : EW'(2 * HW - 1);
    assign txbit  = wide ? s_q.txsr[W-1] : s_q.txsr[HW-1];
    assign mosi   = (s_q.st != ST_IDLE) && txbit;
    assign rin    = cfg.loop ? mosi : miso;

    always_comb begin
        s_d         = s_q;
        s_d.rxv     = 1'b0;
        s_d.en_prev = en;
        tx_ready    = 1'b0;
        load        = 1'b0;
        left_eff    = (en && !s_q.en_prev) ? count : s_q.left;
        s_d.left    = left_eff;

        case (cfg.mode)
            XM_DUPLEX, XM_SEND: want = tx_valid;
            XM_RECV:            want = (left_eff != '0);
            default:            want = 1'b0;
        endcase
        can_go  = en && div_nz && want;
        edge_go = tick && ((s_q.st == ST_SETUP) || (s_q.st == ST_SHIFT));
        e       = (s_q.st == ST_SETUP) ? '0 : s_q.ecnt;
        lead    = ~e[0];
        samp    = cfg.cpha ? ~lead : lead;
        nrx     = samp ? {s_q.rxsr[W-2:0], rin} : s_q.rxsr;

        case (s_q.st)
            ST_IDLE: if (can_go) begin
                load     = 1'b1;
                s_d.st   = ST_SETUP;
            end
            ST_SETUP: if (tick) begin
                s_d.st   = ST_SHIFT;
                s_d.ecnt = EW'(1);
            end
            ST_SHIFT: if (tick) begin
                if (e == last_e) s_d.st   = ST_HOLD;
                else             s_d.ecnt = e + EW'(1);
            end
            default: if (tick) begin
                if (can_go) begin
                    load   = 1'b1;
                    s_d.st = ST_SETUP;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
        endcase

        if (edge_go) begin
            s_d.ph = ~s_q.ph;
            if (samp)                      s_d.rxsr = nrx;
            else if (!(cfg.cpha && e == '0)) s_d.txsr = {s_q.txsr[W-2:0], 1'b0};
            if (e == last_e && cfg.mode != XM_SEND) begin
                s_d.rxv = 1'b1;
                s_d.rxd = wide ? nrx : {{(W - HW){1'b0}}, nrx[HW-1:0]};
            end
        end

        if (load) begin
            tx_ready = (cfg.mode != XM_RECV);
            s_d.txsr = (cfg.mode == XM_RECV) ? '0 : tx_data;
            if (cfg.mode == XM_RECV) s_d.left = left_eff - CNT_W'(1);
        end

        if (!en) begin
            s_d.st  = ST_IDLE;
            s_d.ph  = 1'b0;
            s_d.rxv = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign run      = (s_q.st != ST_IDLE);
    assign ss_n     = run ? ~mask : '1;
    assign sclk     = cfg.cpol ^ s_q.ph;
    assign rx_valid = s_q.rxv;
    assign rx_data  = s_q.rxd;
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
    import spi_eng_pkg::*;
#(
    parameter int NCS     = 4,
    parameter int FRAME_W = 16,
    parameter int DIV_W   = 16,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [15:0]        cfg_wdata,
    input  logic               tx_valid,
    input  logic [FRAME_W-1:0] tx_data,
    output logic               tx_ready,
    output logic               rx_valid,
    output logic [FRAME_W-1:0] rx_data,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NCS-1:0]     ss_n
);
    eng_cfg_t         cfg_w;
    logic [DIV_W-1:0] div_w;
    logic             en_w;
    logic [NCS-1:0]   mask_w;
    logic [CNT_W-1:0] cnt_w;
    logic             tick_w, run_w;

    spi_eng_regs #(.DIV_W(DIV_W), .NCS(NCS), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg(cfg_w), .div(div_w), .en(en_w), .mask(mask_w), .count(cnt_w)
    );

    spi_eng_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run_w), .div(div_w), .tick(tick_w)
    );

    spi_eng_seq #(.W(FRAME_W), .NCS(NCS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en_w), .cfg(cfg_w), .div_nz(div_w != '0),
        .mask(mask_w), .count(cnt_w), .tick(tick_w),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .run(run_w)
    );
endmodule

// File: rtl/spi_engine_chk.sv
module spi_engine_chk #(
    parameter int NCS   = 4,
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [DIV_W-1:0] div,
    input logic [NCS-1:0]   mask,
    input logic [8:0]       ctrl,
    input logic [NCS-1:0]   ss_n,
    input logic             sclk,
    input logic             mosi,
    input logic             rx_valid
);
    AST_SEL_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (~ss_n & ~mask) == '0);                                          // R6
    AST_DIV_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !div[0]);                                                        // R5
    AST_DIV_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> (&ss_n));                                        // R5
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (&ss_n));                                                // R9
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (&ss_n) |-> (sclk == ctrl[7]));                                  // R3
    AST_SEND_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[5:4] == 2'b01) |-> !rx_valid);                             // R4
    AST_RECV_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[5:4] == 2'b10) |-> !mosi);                                 // R4
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($stable(ctrl) && $stable(div) && $stable(mask)));        // R8
endmodule

bind spi_master_engine spi_engine_chk #(.NCS(NCS), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .div(div_w), .mask(mask_w),
    .ctrl(cfg_w), .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .rx_valid(rx_valid)
);

// File: tb/spi_master_engine_bench.sv
module spi_master_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_ready, rx_valid, sclk, mosi, miso;
    logic [15:0] rx_data;
    logic [3:0]  ss_n;

    spi_master_engine u_spi_master_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    // slave model state
    logic        b_cpol = 0, b_cpha = 0;
    int          b_w = 8;
    logic [15:0] b_pat = '0, capw = '0, cap_last = '0, rx_last = '0;
    int          kcap = 0, cap_n = 0, rx_cnt = 0, ss_rise = 0, rdy_cnt = 0, edges = 0;
    int          last_edge = 0, edge_gap = 0, rel_gap = 0, fall_cyc = 0, lead_gap = 0;
    logic        first_pend = 0, prev_sclk = 0;
    logic [3:0]  prev_ss = 4'hF, ss_low = 4'hF;

    assign miso = b_pat[b_w - 1 - kcap];

    // columns: ctrl, divider, tx word, slave pattern, expected rx, expected mosi word
    localparam logic [95:0] VEC [0:7] = '{
        {16'h0007, 16'h0002, 16'h00A5, 16'h003C, 16'h003C, 16'h00A5},
        {16'h0047, 16'h0004, 16'h005A, 16'h00C3, 16'h00C3, 16'h005A},
        {16'h0087, 16'h0006, 16'h0081, 16'h007E, 16'h007E, 16'h0081},
        {16'h00C7, 16'h0002, 16'h000F, 16'h00F0, 16'h00F0, 16'h000F},
        {16'h000F, 16'h0002, 16'hBEEF, 16'h1234, 16'h1234, 16'hBEEF},
        {16'h00CF, 16'h0004, 16'h8001, 16'h7FFE, 16'h7FFE, 16'h8001},
        {16'h0107, 16'h0002, 16'h0096, 16'h0000, 16'h0096, 16'h0096},
        {16'h0007, 16'h0002, 16'hFF12, 16'h00AB, 16'h00AB, 16'h0012}
    };

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ss_n == 4'hF) kcap = 0;
            if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
            if (tx_ready) rdy_cnt++;
            if (prev_ss != 4'hF && ss_n == 4'hF) begin ss_rise++; rel_gap = cyc - last_edge; end
            if (prev_ss == 4'hF && ss_n != 4'hF) begin fall_cyc = cyc; first_pend = 1; end
            if (ss_n != 4'hF) ss_low = ss_n;
            if (ss_n != 4'hF && sclk != prev_sclk) begin
                edge_gap  = cyc - last_edge;
                last_edge = cyc;
                edges++;
                if (first_pend) begin lead_gap = cyc - fall_cyc; first_pend = 0; end
                if (b_cpha ? (sclk == b_cpol) : (sclk != b_cpol)) begin
                    capw = {capw[14:0], mosi};
                    kcap++;
                    if (kcap == b_w) begin
                        cap_last = (b_w == 16) ? capw : (capw & 16'h00FF);
                        cap_n++;
                        kcap = 0;
                    end
                end
            end
            prev_ss = ss_n;
            prev_sclk = sclk;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clr();
        rx_cnt = 0; ss_rise = 0; cap_n = 0; cap_last = '0; kcap = 0; rdy_cnt = 0; edges = 0;
        ss_low = 4'hF; edge_gap = 0; rel_gap = 0; lead_gap = 0; first_pend = 0;
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] d, input logic [3:0] m, input logic [7:0] n);
        wr(2, 16'h0); wr(0, c); wr(1, d); wr(3, {12'h0, m}); wr(4, {8'h0, n});
        b_cpol = c[7]; b_cpha = c[6]; b_w = (c[3:0] == 4'hF) ? 16 : 8;
        clr();
        wr(2, 16'h1);
    endtask

    task automatic push(input logic [15:0] d);
        int t = 0;
        tx_data = d; tx_valid = 1'b1;
        #1;
        while (!tx_ready && t < 3000) begin @(negedge clk); #1; t++; end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        int t = 0;
        while (rx_cnt < n && t < 3000) begin @(negedge clk); #1; t++; end
    endtask

    task automatic wait_rise(input int n);
        int t = 0;
        while (ss_rise < n && t < 3000) begin @(negedge clk); #1; t++; end
    endtask

    initial begin
        logic [15:0] vc, vd, vt, vp, ve, vm;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk(ss_n == 4'hF, "R1 ss_n", ss_n, 4'hF);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(mosi == 1'b0, "R1 mosi", mosi, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);

        // table: R2 widths, R3 clock modes, R10 loopback (row 6)
        for (int i = 0; i < 8; i++) begin
            {vc, vd, vt, vp, ve, vm} = VEC[i];
            b_pat = vp;
            setup(vc, vd, 4'b0001, 8'd0);
            push(vt);
            wait_rx(1);
            wait_rise(1);
            chk(rx_last == ve, $sformatf("R2 R3 R10 row %0d rx", i), rx_last, ve);
            chk(cap_last == vm, $sformatf("R2 R3 R10 row %0d mosi", i), cap_last, vm);
        end

        // R4 transmit-only
        b_pat = 16'h00FF;
        setup(16'h0017, 16'd2, 4'b0001, 8'd0);
        push(16'h006D);
        wait_rise(1); idle(5);
        chk(rx_cnt == 0, "R4 send-only rx strobes", rx_cnt, 0);
        chk(cap_last == 16'h006D, "R4 send-only mosi", cap_last, 16'h006D);

        // R4 / R11 receive-only with count 3
        b_pat = 16'h005C;
        setup(16'h0027, 16'd2, 4'b0001, 8'd3);
        wait_rx(3); wait_rise(1); idle(60);
        chk(rx_cnt == 3, "R11 frame count", rx_cnt, 3);
        chk(rx_last == 16'h005C, "R4 receive-only data", rx_last, 16'h005C);
        chk(cap_last == 16'h0000 && cap_n == 3, "R4 receive-only mosi low", cap_last, 0);
        chk(ss_rise == 1, "R11 select held across frames", ss_rise, 1);

        // R7 back-to-back
        b_pat = 16'h0099;
        setup(16'h0007, 16'd2, 4'b0001, 8'd0);
        push(16'h0011); push(16'h0022);
        wait_rx(2); wait_rise(1);
        chk(ss_rise == 1, "R7 back-to-back select", ss_rise, 1);
        chk(cap_last == 16'h0022, "R7 second word", cap_last, 16'h0022);
        chk(rx_cnt == 2, "R7 two frames", rx_cnt, 2);

        // R5 odd divider 5 acts as 4; R7 lead and release spacing
        b_pat = 16'h0000;
        setup(16'h0007, 16'd5, 4'b0001, 8'd0);
        push(16'h003C);
        wait_rise(1);
        chk(edge_gap == 2, "R5 odd divider half period", edge_gap, 2);
        chk(lead_gap == 2, "R7 select to first edge", lead_gap, 2);
        chk(rel_gap == 2, "R7 last edge to release", rel_gap, 2);

        // R6 select mask
        setup(16'h0007, 16'd2, 4'b0100, 8'd0);
        push(16'h0001);
        wait_rise(1);
        chk(ss_low == 4'b1011, "R6 mask", ss_low, 4'b1011);

        // R8 lock while enabled
        b_pat = 16'h1234;
        setup(16'h0007, 16'd2, 4'b0001, 8'd0);
        wr(0, 16'h000F); wr(1, 16'd8); wr(3, 16'h0002);
        push(16'h003C);
        wait_rx(1); wait_rise(1);
        chk(rx_last == 16'h0034, "R8 frame size locked", rx_last, 16'h0034);
        chk(edge_gap == 1, "R8 divider locked", edge_gap, 1);
        chk(ss_low == 4'b1110, "R8 mask locked", ss_low, 4'b1110);

        // R5 zero divider
        setup(16'h0007, 16'd0, 4'b0001, 8'd0);
        tx_data = 16'h0055; tx_valid = 1'b1;
        idle(100);
        chk(rdy_cnt == 0, "R5 zero divider no start", rdy_cnt, 0);
        chk(edges == 0 && ss_n == 4'hF, "R5 zero divider no edges", edges, 0);
        tx_valid = 1'b0;

        // R4 reserved mode
        setup(16'h0037, 16'd2, 4'b0001, 8'd5);
        tx_valid = 1'b1;
        idle(60);
        chk(rdy_cnt == 0, "R4 reserved mode no accept", rdy_cnt, 0);
        chk(edges == 0 && rx_cnt == 0, "R4 reserved mode no frame", edges, 0);
        tx_valid = 1'b0;

        // R9 abort
        b_pat = 16'hFFFF;
        setup(16'h000F, 16'd8, 4'b0001, 8'd0);
        push(16'hAAAA);
        idle(20);
        wr(2, 16'h0);
        idle(2);
        chk(ss_n == 4'hF, "R9 abort releases select", ss_n, 4'hF);
        chk(sclk == 1'b0, "R9 abort idles clock", sclk, 0);
        idle(100);
        chk(rx_cnt == 0, "R9 abort no rx", rx_cnt, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule